// File: doc/BRIEF.md
# CAN controller protected register file

This block is the software-visible configuration store of a CAN controller. It decodes 32-bit word accesses from a simple request bus and holds several groups of registers: a master control word, interrupt enables, sticky status flags, a bit-timing word, filter configuration words and per-bank filter values, and the words of each transmit mailbox. Each group has its own write guard, which depends on the controller's state. The bit-timing word opens only in initialization mode. A mailbox opens only while it is empty. A filter bank's values open while the bank is inactive or while filter setup is on. The filter layout words open only during filter setup. A write that its guard refuses finishes on the bus like any other write and changes nothing.

The bit engine, the acceptance matching and the receive FIFOs are outside this block. Their state reaches it as level inputs (`init_mode_i`, `mbx_empty_i`) and one-cycle event pulses. The block drives a debug freeze request and two interrupt lines built from sticky, enable-gated flags. Reads are combinational and always return the current contents, whatever the guards say.

Top module: `can_rf_top`

## Requirements
- R1: A write takes effect only when `be_i` is 4'hF and `addr_i[1:0]` is 0. Any narrower or misaligned write changes no register.
- R2: The bit-timing word at 0x10 resets to 0x0123_0000 and keeps only the bits in mask 0xC37F_03FF. It is written only while `init_mode_i` is 1.
- R3: Mailbox m has four words at 0x100 + 16*m + 4*k, each resetting to 0. They are written only while `mbx_empty_i[m]` is 1.
- R4: Filter bank b has two value words at 0x40 + 8*b + 4*k, each resetting to 0. They are written only when bit b of the activation word (0x30, reset 0) is 0 or the filter-setup flag is 1.
- R5: The filter-setup flag is bit 0 of 0x20 and resets to 1. The mode (0x24), scale (0x28) and FIFO-assignment (0x2C) words each hold one bit per bank, reset to 0, and are written only while that flag is 1.
- R6: The control word at 0x00 resets to 0x0001_0002. Only bits 16 and 7:0 are writable. Every other bit reads as 0.
- R7: `freeze_o` is 1 exactly when control bit 16 is 1 and `debug_i` is 1.
- R8: The status word at 0x08 holds sticky flags: bit 0 for error, bit 1 for wakeup, bit 2 for sleep entry. Each flag is set by its event pulse and cleared by writing 1 to its bit. If a set and a clear arrive in the same cycle, the set wins.
- R9: `sts_irq_o` is the OR of each status flag ANDed with its enable bit, which is bit 0, 1 or 2 of the enable word at 0x04 (reset 0).
- R10: Bit 0 of 0x0C is a sticky FIFO1 overrun flag, set by `f1_ovr_evt_i` and cleared by writing 1 to that bit. `f1_irq_o` is that flag ANDed with enable bit 3.
- R11: A read returns the current contents regardless of any guard. An unmapped word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| be_i | input | 4 | Byte enables |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| init_mode_i | input | 1 | Controller is in initialization mode |
| debug_i | input | 1 | System debug halt |
| mbx_empty_i | input | NUM_MBX | Per-mailbox empty status |
| err_evt_i | input | 1 | Error condition pulse |
| wkup_evt_i | input | 1 | Start of frame seen while asleep |
| slp_evt_i | input | 1 | Sleep entry pulse |
| f1_ovr_evt_i | input | 1 | FIFO1 overrun pulse |
| freeze_o | output | 1 | Freeze transmit and receive |
| sts_irq_o | output | 1 | Status-change interrupt |
| f1_irq_o | output | 1 | FIFO1 interrupt |

## Verification
The bench builds the block with four filter banks, three mailboxes and a 10-bit address. With four banks, one bank can be active while its neighbour is not, so both outcomes of the bank guard are reached under the same filter-setup setting. With three mailboxes and an empty pattern of 3'b101, an open mailbox sits next to a locked one and address aliasing between them would be caught. The address width also leaves unmapped words between the register groups, so the read-as-zero rule can be checked there.

// File: rtl/can_rf_pkg.sv
`timescale 1ns/1ps
package can_rf_pkg;
  typedef logic [31:0] word_t;

  // word indices (byte address >> 2)
  localparam int IDX_CTRL    = 0;
  localparam int IDX_IER     = 1;
  localparam int IDX_STS     = 2;
  localparam int IDX_F1S     = 3;
  localparam int IDX_BTR     = 4;
  localparam int IDX_FCTL    = 8;
  localparam int IDX_FMODE   = 9;
  localparam int IDX_FSCALE  = 10;
  localparam int IDX_FASSIGN = 11;
  localparam int IDX_FACT    = 12;
  localparam int IDX_BANK    = 16;
  localparam int IDX_MBX     = 64;
  localparam int BANK_WORDS  = 2;
  localparam int MBX_WORDS   = 4;

  localparam word_t CTRL_RST  = 32'h0001_0002;
  localparam word_t CTRL_MASK = 32'h0001_00FF;
  localparam word_t BTR_RST   = 32'h0123_0000;
  localparam word_t BTR_MASK  = 32'hC37F_03FF;
  localparam int    FRZ_BIT   = 16;

  typedef enum int {EVT_ERR = 0, EVT_WKUP = 1, EVT_SLP = 2, EVT_NUM = 3} evt_e;
endpackage

// File: rtl/can_rf_fbank.sv
`timescale 1ns/1ps
module can_rf_fbank
  import can_rf_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [BANK_WORDS-1:0]            sel_i,
  input  word_t                            wdata_i,
  input  logic                             active_i,
  input  logic                             finit_i,
  output logic [BANK_WORDS-1:0][31:0]      val_o
);
  logic open_w;
  assign open_w = !active_i || finit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
    end else if (wr_i && open_w) begin
      for (int k = 0; k < BANK_WORDS; k++)
        if (sel_i[k]) val_o[k] <= wdata_i;
    end
  end

  // R4
  bank_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !finit_i) |=> $stable(val_o));
endmodule

// File: rtl/can_rf_mbox.sv
`timescale 1ns/1ps
module can_rf_mbox
  import can_rf_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [MBX_WORDS-1:0]            sel_i,
  input  word_t                           wdata_i,
  input  logic                            empty_i,
  output logic [MBX_WORDS-1:0][31:0]      wd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_o <= '0;
    end else if (wr_i && empty_i) begin
      for (int k = 0; k < MBX_WORDS; k++)
        if (sel_i[k]) wd_o[k] <= wdata_i;
    end
  end

  // R3
  mbx_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_i |=> $stable(wd_o));
endmodule

// File: rtl/can_rf_evt.sv
`timescale 1ns/1ps
module can_rf_evt
  import can_rf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EVT_NUM-1:0]  evt_i,
  input  logic                sts_clr_i,
  input  logic [EVT_NUM-1:0]  sts_mask_i,
  input  logic                f1_evt_i,
  input  logic                f1_clr_i,
  input  logic                f1_mask_i,
  input  logic [EVT_NUM:0]    en_i,
  output logic [EVT_NUM-1:0]  sts_o,
  output logic                f1_o,
  output logic                sts_irq_o,
  output logic                f1_irq_o
);
  // set has priority over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_o <= '0;
      f1_o  <= 1'b0;
    end else begin
      sts_o <= evt_i | (sts_o & ~({EVT_NUM{sts_clr_i}} & sts_mask_i));
      f1_o  <= f1_evt_i | (f1_o & ~(f1_clr_i & f1_mask_i));
    end
  end

  assign sts_irq_o = |(sts_o & en_i[EVT_NUM-1:0]);
  assign f1_irq_o  = f1_o & en_i[EVT_NUM];

  // R8
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[EVT_ERR] |=> sts_o[EVT_ERR]);
  // R10
  f1_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f1_evt_i |=> f1_o);
endmodule

// File: rtl/can_rf_top.sv
`timescale 1ns/1ps
module can_rf_top
  import can_rf_pkg::*;
#(
  parameter int NUM_BANK = 4,
  parameter int NUM_MBX  = 3,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [3:0]          be_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                init_mode_i,
  input  logic                debug_i,
  input  logic [NUM_MBX-1:0]  mbx_empty_i,
  input  logic                err_evt_i,
  input  logic                wkup_evt_i,
  input  logic                slp_evt_i,
  input  logic                f1_ovr_evt_i,
  output logic                freeze_o,
  output logic                sts_irq_o,
  output logic                f1_irq_o
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_CTRL    = WIDX_W'(IDX_CTRL);
  localparam logic [WIDX_W-1:0] W_IER     = WIDX_W'(IDX_IER);
  localparam logic [WIDX_W-1:0] W_STS     = WIDX_W'(IDX_STS);
  localparam logic [WIDX_W-1:0] W_F1S     = WIDX_W'(IDX_F1S);
  localparam logic [WIDX_W-1:0] W_BTR     = WIDX_W'(IDX_BTR);
  localparam logic [WIDX_W-1:0] W_FCTL    = WIDX_W'(IDX_FCTL);
  localparam logic [WIDX_W-1:0] W_FMODE   = WIDX_W'(IDX_FMODE);
  localparam logic [WIDX_W-1:0] W_FSCALE  = WIDX_W'(IDX_FSCALE);
  localparam logic [WIDX_W-1:0] W_FASSIGN = WIDX_W'(IDX_FASSIGN);
  localparam logic [WIDX_W-1:0] W_FACT    = WIDX_W'(IDX_FACT);

  logic [WIDX_W-1:0] widx;
  logic              wr_ok;
  assign widx  = addr_i[ADDR_W-1:2];
  assign wr_ok = req_i && we_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00);

  word_t                ctrl_q, btr_q;
  logic [EVT_NUM:0]     ier_q;
  logic                 finit_q;
  logic [NUM_BANK-1:0]  fmode_q, fscale_q, fassign_q, fact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      btr_q     <= BTR_RST;
      ier_q     <= '0;
      finit_q   <= 1'b1;
      fmode_q   <= '0;
      fscale_q  <= '0;
      fassign_q <= '0;
      fact_q    <= '0;
    end else if (wr_ok) begin
      if (widx == W_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (widx == W_IER)  ier_q  <= wdata_i[EVT_NUM:0];
      if (widx == W_BTR && init_mode_i) btr_q <= wdata_i & BTR_MASK;
      if (widx == W_FCTL) finit_q <= wdata_i[0];
      if (widx == W_FACT) fact_q  <= wdata_i[NUM_BANK-1:0];
      if (finit_q) begin
        if (widx == W_FMODE)   fmode_q   <= wdata_i[NUM_BANK-1:0];
        if (widx == W_FSCALE)  fscale_q  <= wdata_i[NUM_BANK-1:0];
        if (widx == W_FASSIGN) fassign_q <= wdata_i[NUM_BANK-1:0];
      end
    end
  end

  assign freeze_o = ctrl_q[FRZ_BIT] & debug_i;

  // filter banks
  logic [BANK_WORDS-1:0][31:0] bank_v [NUM_BANK];
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [BANK_WORDS-1:0] sel;
    for (genvar k = 0; k < BANK_WORDS; k++) begin : g_sel
      assign sel[k] = (widx == WIDX_W'(IDX_BANK + BANK_WORDS*b + k));
    end
    can_rf_fbank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_ok),
      .sel_i    (sel),
      .wdata_i  (wdata_i),
      .active_i (fact_q[b]),
      .finit_i  (finit_q),
      .val_o    (bank_v[b])
    );
  end

  // transmit mailboxes
  logic [MBX_WORDS-1:0][31:0] mbx_v [NUM_MBX];
  for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
    logic [MBX_WORDS-1:0] sel;
    for (genvar k = 0; k < MBX_WORDS; k++) begin : g_sel
      assign sel[k] = (widx == WIDX_W'(IDX_MBX + MBX_WORDS*m + k));
    end
    can_rf_mbox u_mbx (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_ok),
      .sel_i   (sel),
      .wdata_i (wdata_i),
      .empty_i (mbx_empty_i[m]),
      .wd_o    (mbx_v[m])
    );
  end

  // events and interrupts
  logic [EVT_NUM-1:0] sts_w;
  logic               f1_w;
  can_rf_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      ({slp_evt_i, wkup_evt_i, err_evt_i}),
    .sts_clr_i  (wr_ok && widx == W_STS),
    .sts_mask_i (wdata_i[EVT_NUM-1:0]),
    .f1_evt_i   (f1_ovr_evt_i),
    .f1_clr_i   (wr_ok && widx == W_F1S),
    .f1_mask_i  (wdata_i[0]),
    .en_i       (ier_q),
    .sts_o      (sts_w),
    .f1_o       (f1_w),
    .sts_irq_o  (sts_irq_o),
    .f1_irq_o   (f1_irq_o)
  );

  // read mux, guard independent
  always_comb begin
    rdata_o = '0;
    case (widx)
      W_CTRL:    rdata_o = ctrl_q;
      W_IER:     rdata_o = 32'(ier_q);
      W_STS:     rdata_o = 32'(sts_w);
      W_F1S:     rdata_o = 32'(f1_w);
      W_BTR:     rdata_o = btr_q;
      W_FCTL:    rdata_o = 32'(finit_q);
      W_FMODE:   rdata_o = 32'(fmode_q);
      W_FSCALE:  rdata_o = 32'(fscale_q);
      W_FASSIGN: rdata_o = 32'(fassign_q);
      W_FACT:    rdata_o = 32'(fact_q);
      default:   rdata_o = '0;
    endcase
    for (int b = 0; b < NUM_BANK; b++)
      for (int k = 0; k < BANK_WORDS; k++)
        if (widx == WIDX_W'(IDX_BANK + BANK_WORDS*b + k)) rdata_o = bank_v[b][k];
    for (int m = 0; m < NUM_MBX; m++)
      for (int k = 0; k < MBX_WORDS; k++)
        if (widx == WIDX_W'(IDX_MBX + MBX_WORDS*m + k)) rdata_o = mbx_v[m][k];
  end

  // R1
  part_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (be_i != 4'hF || addr_i[1:0] != 2'b00))
      |=> ($stable(ctrl_q) && $stable(btr_q) && $stable(ier_q)));
  // R2
  btr_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_mode_i |=> $stable(btr_q));
  // R5
  cfg_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !finit_q |=> ($stable(fmode_q) && $stable(fscale_q) && $stable(fassign_q)));
endmodule

// File: tb/can_rf_top_tb_top.sv
`timescale 1ns/1ps
module can_rf_top_tb_top;
  localparam int NB = 4;
  localparam int NM = 3;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req = 0, we = 0;
  logic [3:0]    be = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata;
  logic          init_mode = 0, debug = 0;
  logic [NM-1:0] mbx_empty = 0;
  logic          err_ev = 0, wk_ev = 0, slp_ev = 0, f1_ev = 0;
  logic          freeze, sts_irq, f1_irq;

  can_rf_top #(.NUM_BANK(NB), .NUM_MBX(NM), .ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .init_mode_i(init_mode), .debug_i(debug), .mbx_empty_i(mbx_empty),
    .err_evt_i(err_ev), .wkup_evt_i(wk_ev), .slp_evt_i(slp_ev),
    .f1_ovr_evt_i(f1_ev), .freeze_o(freeze), .sts_irq_o(sts_irq),
    .f1_irq_o(f1_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_ctrl, m_btr;
  logic [3:0]  m_ier;
  logic [2:0]  m_sts;
  logic        m_f1, m_finit;
  logic [NB-1:0] m_fmode, m_fscale, m_fassign, m_fact;
  logic [31:0] m_bank [NB][2];
  logic [31:0] m_mbx  [NM][4];

  always @(posedge clk or negedge rst_n) begin
    bit full;
    int wi;
    if (!rst_n) begin
      m_ctrl = 32'h0001_0002; m_btr = 32'h0123_0000; m_ier = 0; m_sts = 0;
      m_f1 = 0; m_finit = 1; m_fmode = 0; m_fscale = 0; m_fassign = 0; m_fact = 0;
      for (int b = 0; b < NB; b++) for (int k = 0; k < 2; k++) m_bank[b][k] = 0;
      for (int m = 0; m < NM; m++) for (int k = 0; k < 4; k++) m_mbx[m][k] = 0;
    end else begin
      full = req && we && be == 4'hF && addr[1:0] == 2'b00;
      wi = int'(addr >> 2);
      m_sts[0] <= err_ev | (m_sts[0] & !(full && wi == 2 && wdata[0]));
      m_sts[1] <= wk_ev  | (m_sts[1] & !(full && wi == 2 && wdata[1]));
      m_sts[2] <= slp_ev | (m_sts[2] & !(full && wi == 2 && wdata[2]));
      m_f1     <= f1_ev  | (m_f1 & !(full && wi == 3 && wdata[0]));
      if (full) begin
        if (wi == 0) m_ctrl <= wdata & 32'h0001_00FF;
        if (wi == 1) m_ier <= wdata[3:0];
        if (wi == 4 && init_mode) m_btr <= wdata & 32'hC37F_03FF;
        if (wi == 8) m_finit <= wdata[0];
        if (wi == 9 && m_finit) m_fmode <= wdata[NB-1:0];
        if (wi == 10 && m_finit) m_fscale <= wdata[NB-1:0];
        if (wi == 11 && m_finit) m_fassign <= wdata[NB-1:0];
        if (wi == 12) m_fact <= wdata[NB-1:0];
        for (int b = 0; b < NB; b++) for (int k = 0; k < 2; k++)
          if (wi == 16 + 2*b + k && (!m_fact[b] || m_finit)) m_bank[b][k] <= wdata;
        for (int m = 0; m < NM; m++) for (int k = 0; k < 4; k++)
          if (wi == 64 + 4*m + k && mbx_empty[m]) m_mbx[m][k] <= wdata;
      end
    end
  end

  function automatic logic [31:0] mrd(input logic [AW-1:0] a);
    int wi = int'(a >> 2);
    logic [31:0] r = 0;
    case (wi)
      0: r = m_ctrl;  1: r = 32'(m_ier);  2: r = 32'(m_sts);  3: r = 32'(m_f1);
      4: r = m_btr;   8: r = 32'(m_finit); 9: r = 32'(m_fmode);
      10: r = 32'(m_fscale); 11: r = 32'(m_fassign); 12: r = 32'(m_fact);
      default: r = 0;
    endcase
    for (int b = 0; b < NB; b++) for (int k = 0; k < 2; k++)
      if (wi == 16 + 2*b + k) r = m_bank[b][k];
    for (int m = 0; m < NM; m++) for (int k = 0; k < 4; k++)
      if (wi == 64 + 4*m + k) r = m_mbx[m][k];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle output comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(freeze === (m_ctrl[16] & debug), "R7 freeze", 32'(freeze), 32'(m_ctrl[16] & debug));
      chk(sts_irq === |(m_sts & m_ier[2:0]), "R9 sts_irq", 32'(sts_irq), 32'(|(m_sts & m_ier[2:0])));
      chk(f1_irq === (m_f1 & m_ier[3]), "R10 f1_irq", 32'(f1_irq), 32'(m_f1 & m_ier[3]));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(posedge clk); #2;
    req = 1; we = 1; addr = a; wdata = d; be = b;
    @(posedge clk); #2;
    req = 0; we = 0; be = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    @(posedge clk); #2;
    req = 1; we = 0; addr = a;
    @(negedge clk);
    chk(rdata === mrd(a), tag, rdata, mrd(a));
    req = 0;
  endtask

  task automatic rd_fix(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    req = 1; we = 0; addr = a;
    @(negedge clk);
    chk(rdata === exp, tag, rdata, exp);
    req = 0;
  endtask

  task automatic pulse(input bit e, input bit w, input bit s, input bit f);
    @(posedge clk); #2;
    err_ev = e; wk_ev = w; slp_ev = s; f1_ev = f;
    @(posedge clk); #2;
    err_ev = 0; wk_ev = 0; slp_ev = 0; f1_ev = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // reset state
    rd_fix(10'h000, 32'h0001_0002, "R6 reset ctrl");
    rd_fix(10'h010, 32'h0123_0000, "R2 reset btr");
    rd_fix(10'h020, 32'h1, "R5 reset finit");
    rd(10'h108, "R3 reset mbx");

    // R1: partial and misaligned writes
    wr(10'h000, 32'h0000_00AA, 4'h3);
    rd_fix(10'h000, 32'h0001_0002, "R1 partial be");
    wr(10'h002, 32'h0000_00AA);
    rd_fix(10'h000, 32'h0001_0002, "R1 misaligned");

    // R6: reserved bits
    wr(10'h000, 32'hFFFF_FFFF);
    rd_fix(10'h000, 32'h0001_00FF, "R6 reserved zero");

    // R2: bit timing guard
    wr(10'h010, 32'hFFFF_FFFF);
    rd_fix(10'h010, 32'h0123_0000, "R2 blocked");
    init_mode = 1;
    wr(10'h010, 32'hFFFF_FFFF);
    rd_fix(10'h010, 32'hC37F_03FF, "R2 open masked");
    init_mode = 0;

    // R5: filter layout guard
    wr(10'h024, 32'h5);
    wr(10'h028, 32'h3);
    wr(10'h02C, 32'h9);
    rd_fix(10'h024, 32'h5, "R5 mode open");
    wr(10'h020, 32'h0);
    wr(10'h024, 32'hA);
    wr(10'h02C, 32'h6);
    rd_fix(10'h024, 32'h5, "R5 mode blocked");
    rd_fix(10'h02C, 32'h9, "R5 assign blocked");
    rd(10'h028, "R5 scale");

    // R4: bank value guard (bank 1 active, setup off)
    wr(10'h030, 32'h2);
    wr(10'h048, 32'hDEAD_0001);
    wr(10'h040, 32'hBEEF_0000);
    rd_fix(10'h048, 32'h0, "R4 active blocked");
    rd_fix(10'h040, 32'hBEEF_0000, "R4 inactive open");
    wr(10'h020, 32'h1);
    wr(10'h04C, 32'h1234_5678);
    rd_fix(10'h04C, 32'h1234_5678, "R4 setup open");

    // R3: mailbox guard
    mbx_empty = 3'b101;
    wr(10'h118, 32'hCAFE_0001);
    wr(10'h100, 32'hCAFE_0000);
    wr(10'h12C, 32'hCAFE_0002);
    rd_fix(10'h118, 32'h0, "R3 full blocked");
    rd_fix(10'h100, 32'hCAFE_0000, "R3 empty open");
    rd_fix(10'h12C, 32'hCAFE_0002, "R3 mbx2 open");
    mbx_empty = 3'b000;
    wr(10'h100, 32'h0BAD_0BAD);
    rd(10'h100, "R11 read while locked");

    // R7: freeze
    debug = 1;
    repeat (2) @(posedge clk);
    wr(10'h000, 32'h0000_0002);
    repeat (2) @(posedge clk);
    wr(10'h000, 32'h0001_0000);
    debug = 0;
    @(posedge clk);

    // R8/R9: sticky flags and irq
    wr(10'h004, 32'h3);
    pulse(1, 0, 0, 0);
    rd_fix(10'h008, 32'h1, "R8 err set");
    wr(10'h008, 32'h1);
    rd_fix(10'h008, 32'h0, "R8 w1c");
    pulse(0, 0, 1, 0);
    rd_fix(10'h008, 32'h4, "R9 slp flag disabled");
    @(posedge clk); #2;
    wk_ev = 1; req = 1; we = 1; be = 4'hF; addr = 10'h008; wdata = 32'h2;
    @(posedge clk); #2;
    wk_ev = 0; req = 0; we = 0;
    rd_fix(10'h008, 32'h6, "R8 set beats clear");
    wr(10'h008, 32'h7);
    rd(10'h008, "R8 clear all");

    // R10: fifo1 overrun
    pulse(0, 0, 0, 1);
    rd_fix(10'h00C, 32'h1, "R10 ovr set");
    wr(10'h004, 32'h8);
    repeat (2) @(posedge clk);
    wr(10'h00C, 32'h1);
    rd_fix(10'h00C, 32'h0, "R10 ovr clear");

    // R11: unmapped words
    rd_fix(10'h03C, 32'h0, "R11 unmapped");
    rd_fix(10'h0F0, 32'h0, "R11 gap");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R11 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule